// File: doc/BRIEF.md
# PWM Carrier Chopper Stage

This block sits between a PWM generator and the output pads. Its job is to turn each PWM high phase into a burst of high-frequency pulses that can pass through a pulse transformer. Each PWM rising edge opens a wide first pulse that lasts a programmed number of carrier periods. The rest of the high phase is then chopped by a carrier with a programmable duty in eighths. The carrier rate is set by dividing the block clock.

There are two channels, A and B. Both use the same carrier settings, but each keeps its own divider, carrier phase and first-pulse state. Every PWM pulse therefore starts its chopping pattern from the beginning. A polarity bit inverts the inputs before any processing, and a second bit inverts the outputs after chopping. When the enable bit is clear, chopping is bypassed, and the inputs pass through with only the two polarity bits applied.

All settings arrive on plain configuration inputs and are used live. The outputs come from registers.

Top module: `pwm_chopper`

## Requirements
- R1: While reset is high and on the first edge after it, both outputs are 0; all configuration inputs at 0 give bypass with no inversion.
- R2: With `cfg_enable` = 0, each output equals its processed input (`pwm_in[i]` XOR `cfg_in_invert`) XOR `cfg_out_invert`, with no chopping.
- R3: The carrier phase advances by one step every `cfg_prescale`+1 clock cycles, and it runs through 8 steps (phases 0..7) per carrier period.
- R4: After the first-pulse window, a high processed input is output only during carrier phases below `cfg_duty`; a duty of 0 gives a constant low output.
- R5: After a processed rising edge, the output stays high without chopping for `cfg_first_width` × 8 × (`cfg_prescale`+1) cycles.
- R6: A `cfg_first_width` of 0 opens no first-pulse window, and chopping starts on the first cycle of the pulse.
- R7: Every processed rising edge restarts that channel's divider, sets its carrier phase to 0 and reloads its first-pulse count, even after a low phase of a single cycle.
- R8: When a processed input goes low, the output drops on the next output update, even inside the first-pulse window.
- R9: `cfg_in_invert` = 1 inverts both inputs before edge detection, so a low input level is the phase that gets chopped.
- R10: `cfg_out_invert` = 1 inverts both outputs after chopping, and also in bypass.
- R11: Channels A (index 0) and B (index 1) keep separate divider, phase and first-pulse state; a pulse on one does not shift the pattern of the other.
- R12: An input level sampled at clock edge k shows at the output after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | 1 = chop, 0 = bypass |
| cfg_prescale | input | PRESC_W (4) | Carrier step length minus one, in clock cycles |
| cfg_duty | input | DUTY_W (3) | Number of high carrier phases out of 8 |
| cfg_first_width | input | FIRST_W (4) | First-pulse length in carrier periods |
| cfg_in_invert | input | 1 | Invert both inputs |
| cfg_out_invert | input | 1 | Invert both outputs |
| pwm_in | input | NUM_CH (2) | PWM inputs, bit 0 = A, bit 1 = B |
| chop_out | output | NUM_CH (2) | Chopped outputs, bit 0 = A, bit 1 = B |

## Verification
The hardest case to reach is a PWM edge that falls on a boundary inside the chopping state. Examples are a falling edge inside the first-pulse window, and a rising edge that follows a single low cycle while the carrier is partway through a period. The stimulus reaches these cases by timing pulses in exact cycle counts against the programmed prescale and width. Examples are a 20-cycle pulse against a 32-cycle window, and two 12-cycle pulses separated by one low cycle. A cycle-accurate reference computes every expected output bit. Staggered pulses on A and B, together with a change of input polarity while the pins are held, show that the two channels keep separate state.

// File: rtl/chop_pkg.sv
package chop_pkg;
  // Default widths of the configuration fields.
  localparam int unsigned DEF_PRESC_W = 4;
  localparam int unsigned DEF_DUTY_W  = 3;
  localparam int unsigned DEF_FIRST_W = 4;
  localparam int unsigned DEF_NUM_CH  = 2;

  // Channel index names.
  typedef enum int unsigned {
    CH_A = 0,
    CH_B = 1
  } chop_ch_e;
endpackage

// File: rtl/chop_phase.sv
// Per-channel carrier timing: clock divider, carrier phase and first-pulse
// down-counter. A restart puts all three back to the start of a PWM pulse.
module chop_phase #(
  parameter int unsigned PRESC_W = 4,
  parameter int unsigned DUTY_W  = 3,
  parameter int unsigned FIRST_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               advance,
  input  logic [PRESC_W-1:0] presc,
  input  logic [FIRST_W-1:0] first_width,
  output logic [DUTY_W-1:0]  phase,
  output logic               first_active
);
  localparam logic [DUTY_W-1:0] LAST_PHASE = {DUTY_W{1'b1}};

  logic [PRESC_W-1:0] div_q;
  logic [DUTY_W-1:0]  ph_q;
  logic [FIRST_W-1:0] fp_q;
  logic               tick;

  assign tick = (div_q >= presc);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ph_q  <= '0;
      fp_q  <= '0;
    end else if (restart) begin
      div_q <= '0;
      ph_q  <= '0;
      fp_q  <= first_width;
    end else if (advance) begin
      if (tick) begin
        div_q <= '0;
        ph_q  <= ph_q + 1'b1;
        if (ph_q == LAST_PHASE && fp_q != '0)
          fp_q <= fp_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign phase        = ph_q;
  assign first_active = (fp_q != '0);

  // R3: with a steady prescale, the divider never passes the step length
  assert_div_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(presc) == presc && $past(div_q) <= $past(presc)) |-> (div_q <= presc));

  // R3: the phase moves by exactly one on each divider tick
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(advance) && !$past(restart) && $past(tick))
      |-> (ph_q == DUTY_W'($past(ph_q) + 1'b1)));

  // R7: a restart loads the first-pulse count and clears the phase
  assert_restart_load_R7: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (fp_q == $past(first_width) && ph_q == '0 && div_q == '0));

  // R5: without a restart the first-pulse count never grows
  assert_first_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(restart) |-> (fp_q <= $past(fp_q)));
endmodule

// File: rtl/chop_channel.sv
// One chopper channel: input polarity, edge detection, carrier gating,
// bypass and output polarity, ending in a registered output.
module chop_channel #(
  parameter int unsigned PRESC_W = 4,
  parameter int unsigned DUTY_W  = 3,
  parameter int unsigned FIRST_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwm_raw,
  input  logic               en,
  input  logic               in_inv,
  input  logic               out_inv,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DUTY_W-1:0]  duty,
  input  logic [FIRST_W-1:0] first_width,
  output logic               chop_o
);
  logic              lvl;
  logic              lvl_q;
  logic              rise;
  logic              advance;
  logic [DUTY_W-1:0] phase;
  logic              first_active;
  logic              carrier;
  logic              shaped;
  logic              out_q;

  assign lvl     = pwm_raw ^ in_inv;
  assign rise    = lvl & ~lvl_q;
  assign advance = lvl_q & ~rise;

  chop_phase #(
    .PRESC_W(PRESC_W),
    .DUTY_W (DUTY_W),
    .FIRST_W(FIRST_W)
  ) i_phase (
    .clk         (clk),
    .rst         (rst),
    .restart     (rise),
    .advance     (advance),
    .presc       (presc),
    .first_width (first_width),
    .phase       (phase),
    .first_active(first_active)
  );

  assign carrier = (phase < duty);
  assign shaped  = lvl_q & (first_active | carrier);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      out_q <= (en ? shaped : lvl_q) ^ out_inv;
    end
  end

  assign chop_o = out_q;

  // R1: reset forces the output low on the following edge
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (out_q == 1'b0));

  // R2: in bypass the output tracks the sampled level through the polarity bit
  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (out_q == ($past(lvl_q) ^ $past(out_inv))));

  // R8: a low sampled level always gives an inactive output when chopping
  assert_fall_cut_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(lvl_q)) |-> (out_q == $past(out_inv)));

  // R5: inside the first-pulse window a high level passes unchopped
  assert_first_pass_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(lvl_q) && $past(first_active)) |-> (out_q == !$past(out_inv)));

  // R4: zero duty blocks everything outside the first-pulse window
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(duty) == '0 && !$past(first_active)) |-> (out_q == $past(out_inv)));
endmodule

// File: rtl/pwm_chopper.sv
// Carrier chopper for NUM_CH PWM channels that share one configuration.
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int unsigned PRESC_W = DEF_PRESC_W,
  parameter int unsigned DUTY_W  = DEF_DUTY_W,
  parameter int unsigned FIRST_W = DEF_FIRST_W,
  parameter int unsigned NUM_CH  = DEF_NUM_CH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_enable,
  input  logic [PRESC_W-1:0] cfg_prescale,
  input  logic [DUTY_W-1:0]  cfg_duty,
  input  logic [FIRST_W-1:0] cfg_first_width,
  input  logic               cfg_in_invert,
  input  logic               cfg_out_invert,
  input  logic [NUM_CH-1:0]  pwm_in,
  output logic [NUM_CH-1:0]  chop_out
);
  // R11: every channel gets its own timing state; only configuration is shared
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chop_channel #(
      .PRESC_W(PRESC_W),
      .DUTY_W (DUTY_W),
      .FIRST_W(FIRST_W)
    ) i_channel (
      .clk        (clk),
      .rst        (rst),
      .pwm_raw    (pwm_in[ch]),
      .en         (cfg_enable),
      .in_inv     (cfg_in_invert),
      .out_inv    (cfg_out_invert),
      .presc      (cfg_prescale),
      .duty       (cfg_duty),
      .first_width(cfg_first_width),
      .chop_o     (chop_out[ch])
    );
  end
endmodule

// File: tb/test_pwm_chopper.sv
module test_pwm_chopper;
  localparam int PW = 4;
  localparam int DW = 3;
  localparam int FW = 4;
  localparam int NC = 2;
  localparam int STEPS = 1 << DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          c_en = 1'b0;
  logic [PW-1:0] c_p = '0;
  logic [DW-1:0] c_d = '0;
  logic [FW-1:0] c_w = '0;
  logic          c_ii = 1'b0;
  logic          c_oi = 1'b0;
  logic [NC-1:0] pwm = '0;
  logic [NC-1:0] chop_out;

  always #5 clk = ~clk;

  pwm_chopper #(.PRESC_W(PW), .DUTY_W(DW), .FIRST_W(FW), .NUM_CH(NC)) i_pwm_chopper (
    .clk(clk), .rst(rst), .cfg_enable(c_en), .cfg_prescale(c_p), .cfg_duty(c_d),
    .cfg_first_width(c_w), .cfg_in_invert(c_ii), .cfg_out_invert(c_oi),
    .pwm_in(pwm), .chop_out(chop_out));

  typedef struct {
    int            due;
    logic [NC-1:0] val;
    string         req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    prev_m [NC];
  int    n_m [NC];

  // Monitor: compare every expected item on the cycle it falls due.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      checks++;
      if (chop_out !== q[0].val) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %b expected %b", q[0].req, cyc, chop_out, q[0].val);
      end
      void'(q.pop_front());
    end
  end

  // Reference model from the requirements; call it right after a falling edge.
  task automatic drive(input logic [NC-1:0] raw, input bit chk, input string req);
    logic [NC-1:0] e;
    item_t it;
    pwm = raw;
    for (int ch = 0; ch < NC; ch++) begin
      bit x;
      bit pass;
      int per;
      x = raw[ch] ^ c_ii;
      per = int'(c_p) + 1;
      if (x && !prev_m[ch]) n_m[ch] = 0;          // R7 restart
      else if (prev_m[ch]) n_m[ch] = n_m[ch] + 1;
      pass = (n_m[ch] < int'(c_w) * STEPS * per) ||              // R5, R6
             (((n_m[ch] / per) % STEPS) < int'(c_d));            // R3, R4
      e[ch] = (c_en ? (x && pass) : x) ^ c_oi;                   // R2, R8, R10
      prev_m[ch] = x;
    end
    if (chk) begin
      it.due = cyc + 2;                                          // R12 latency
      it.val = e;
      it.req = req;
      q.push_back(it);
    end
  endtask

  task automatic step(input logic [NC-1:0] raw, input bit chk, input string req);
    @(negedge clk);
    drive(raw, chk, req);
  endtask

  task automatic hold(input logic [NC-1:0] raw, input int len, input string req);
    for (int i = 0; i < len; i++) step(raw, 1'b1, req);
  endtask

  task automatic set_cfg(input logic en, input int p, input int d, input int w,
                         input logic ii, input logic oi);
    logic [NC-1:0] keep;
    keep = pwm;
    step(keep, 1'b0, "");
    step(keep, 1'b0, "");
    @(negedge clk);
    c_en = en; c_p = PW'(p); c_d = DW'(d); c_w = FW'(w); c_ii = ii; c_oi = oi;
    drive(keep, 1'b0, "");
    step(keep, 1'b0, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int ch = 0; ch < NC; ch++) begin prev_m[ch] = 1'b0; n_m[ch] = 0; end
    repeat (4) @(posedge clk);
    #1;
    checks++;  // R1 reset state
    if (chop_out !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 00", chop_out);
    end
    @(negedge clk);
    rst = 1'b0;
    hold(2'b00, 3, "R1 idle after reset");

    // R2 and R12: bypass passes a toggling pattern with two-cycle latency
    step(2'b01, 1, "R2 R12"); step(2'b11, 1, "R2 R12"); step(2'b10, 1, "R2 R12");
    step(2'b00, 1, "R2 R12"); step(2'b01, 1, "R2 R12"); step(2'b00, 1, "R2 R12");
    step(2'b10, 1, "R2 R12"); step(2'b11, 1, "R2 R12"); step(2'b00, 1, "R2 R12");

    // R6 and R4: no first pulse, half duty, fastest carrier
    set_cfg(1'b1, 0, 4, 0, 1'b0, 1'b0);
    hold(2'b01, 40, "R4 R6 chop from start");
    hold(2'b00, 4, "R4 R6 idle");

    // R3 and R5: prescale 2, duty 3, one carrier period of first pulse, both channels
    set_cfg(1'b1, 2, 3, 1, 1'b0, 1'b0);
    hold(2'b11, 60, "R3 R5 window then carrier");
    hold(2'b00, 4, "R3 R5 idle");

    // R8: falling edge inside a 32-cycle window, then R4 zero duty after the window
    set_cfg(1'b1, 1, 0, 2, 1'b0, 1'b0);
    hold(2'b01, 20, "R8 inside window");
    hold(2'b00, 5, "R8 cut inside window");
    hold(2'b01, 50, "R4 zero duty after window");
    hold(2'b00, 4, "R4 idle");

    // R7: one low cycle between pulses restarts the pattern
    set_cfg(1'b1, 0, 2, 1, 1'b0, 1'b0);
    hold(2'b10, 12, "R7 first pulse");
    hold(2'b00, 1, "R7 one low cycle");
    hold(2'b10, 12, "R7 restarted pulse");
    hold(2'b00, 4, "R7 idle");

    // R9: inverted inputs, pins held high are idle, low is chopped
    step(2'b11, 0, "");
    set_cfg(1'b1, 0, 3, 1, 1'b1, 1'b0);
    hold(2'b11, 4, "R9 idle high pins");
    hold(2'b00, 24, "R9 low phase chopped");
    hold(2'b11, 4, "R9 back to idle");

    // R10: output inversion, chopping then bypass
    set_cfg(1'b1, 0, 5, 1, 1'b0, 1'b1);
    hold(2'b00, 3, "R10 idle inverted");
    hold(2'b11, 20, "R10 chopped inverted");
    hold(2'b00, 3, "R10 idle inverted");
    set_cfg(1'b0, 0, 5, 1, 1'b0, 1'b1);
    step(2'b01, 1, "R10 R2 bypass inverted"); step(2'b10, 1, "R10 R2 bypass inverted");
    step(2'b00, 1, "R10 R2 bypass inverted");

    // R11: staggered pulses keep separate patterns
    set_cfg(1'b1, 1, 5, 1, 1'b0, 1'b0);
    hold(2'b01, 7, "R11 A only");
    hold(2'b11, 23, "R11 both, B offset");
    hold(2'b10, 15, "R11 B only");
    hold(2'b00, 4, "R11 idle");

    repeat (4) step(2'b00, 0, "");
    while (q.size() > 0) @(posedge clk);
    #2;
    finish_run();
  end
endmodule